// File: doc/BRIEF.md
# Cascaded Digital Potentiometer Chain Host

This block is the host end of a three-wire serial link (enable, clock, bidirectional data) that reaches a chain of N cascaded dual-potentiometer devices. Each device holds a 17-bit setting word. The block moves the whole chain's settings in one transfer of 17×N bits. A write drives a parallel vector out serially. A read releases the data line. The chain's cascade output is looped back to the data line, and the block samples each bit as the chain rotates its own contents. After exactly 17×N clocks the contents are back where they started, so a read leaves the settings unchanged.

A one-cycle `start_i` with `rd_i` begins a transfer. `busy_o` covers the whole frame, and `done_o` pulses once when the frame ends. All serial timing comes from one compile-time count, `PHASE_CYC`. Each serial phase (setup, enable lead, clock high, clock low, enable tail) lasts exactly that many system cycles. The default of 3 cycles at 50 MHz gives 60 ns phases and an 8.3 MHz serial clock.

States:
- **ST_IDLE**: the link is quiet.
- **ST_SETUP**: enable is low, and the data line is driven for a write or released for a read. At its end the first read bit is sampled.
- **ST_LEAD**: enable is high and the clock is low.
- **ST_HIGH** and **ST_LOW**: these alternate once per bit.
- **ST_TRAIL**: enable is held high with the clock low.

Transitions:
- ST_IDLE→ST_SETUP on an accepted start.
- ST_SETUP→ST_LEAD after one phase.
- ST_LEAD→ST_HIGH after one phase.
- ST_HIGH→ST_LOW after one phase, or ST_HIGH→ST_TRAIL after the last bit.
- ST_LOW→ST_HIGH after one phase.
- ST_TRAIL→ST_IDLE after one phase, with `done_o` pulsing on entry to ST_IDLE.

Top module: `pot_chain_host`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ser_en_o`, `ser_clk_o` and `ser_dq_oe_o` are all low.
- R2: Every transfer, read or write, produces exactly W = 17×N_DEV rising edges on `ser_clk_o` while `ser_en_o` is high.
- R3: A write sends `wr_data_i` most significant bit first. Field k occupies bits [17k+16:17k], with bit 16 the stack-select bit, bits 15:8 wiper 1 and bits 7:0 wiper 0. The highest field is for the device farthest from the host, so a chain that shifts in on each rising edge ends up holding exactly `wr_data_i`.
- R4: During a read, `ser_dq_oe_o` stays low for the whole transfer. The first bit is sampled before `ser_en_o` rises, and each later bit is sampled after a rising edge. At `done_o`, `rd_data_o` holds the chain contents in the R3 layout, and the chain is left unchanged. During a write, `ser_dq_oe_o` stays high for the whole transfer.
- R5: `ser_en_o` rises PHASE_CYC cycles before the first clock rise. It falls PHASE_CYC cycles after the last clock fall.
- R6: Every high phase and every low phase of `ser_clk_o` lasts exactly PHASE_CYC system cycles.
- R7: During a write, `ser_dq_o` does not change while `ser_clk_o` is high or on the cycle it rises. It changes only during low phases.
- R8: `busy_o` falls in the same cycle as `ser_en_o` falls. `done_o` is high for exactly that one cycle.
- R9: A start request while `busy_o` is high is ignored. The running transfer completes unchanged, and no second transfer follows.
- R10: `busy_o` stays high for exactly PHASE_CYC×(2W+2) cycles, starting in the cycle after `start_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| rd_i | input | 1 | 1 = read transfer, 0 = write, sampled with start |
| wr_data_i | input | 17×N_DEV | Settings to write, R3 layout |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rd_data_o | output | 17×N_DEV | Captured settings, valid at done after a read |
| ser_en_o | output | 1 | Serial enable to the chain |
| ser_clk_o | output | 1 | Serial clock to the chain |
| ser_dq_o | output | 1 | Serial data driven by the host |
| ser_dq_oe_o | output | 1 | Data output enable, low during reads |
| ser_dq_i | input | 1 | Data line value as seen by the host |

## Verification
`busy_o` is due one cycle after the edge that samples `start_i`. It lasts PHASE_CYC×(2W+2) cycles, and `done_o` coincides with the first idle cycle. The bench samples every output on the falling system clock edge, from the first falling edge after start until `done_o`. It counts busy cycles, clock rises and phase lengths, and compares them with the figures above. A chain model in the bench shifts on each serial rising edge and feeds its last bit back to the data line. After each transfer, its contents and `rd_data_o` are compared against the vector written or preloaded.

// File: rtl/pot_host_pkg.sv
package pot_host_pkg;
    localparam int unsigned FIELD_W = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } host_state_t;
endpackage

// File: rtl/pot_phase_timer.sv
module pot_phase_timer #(
    parameter int unsigned PHASE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = $clog2(PHASE_CYC) + 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(PHASE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pot_frame_shifter.sv
module pot_frame_shifter #(
    parameter int unsigned W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] word,
    output logic         msb
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_val;
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], ser_in};
        end
    end

    assign word = sreg_q;
    assign msb  = sreg_q[W-1];
endmodule

// File: rtl/pot_chain_host.sv
module pot_chain_host
    import pot_host_pkg::*;
#(
    parameter int unsigned N_DEV     = 2,
    parameter int unsigned PHASE_CYC = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      rd_i,
    input  logic [FIELD_W*N_DEV-1:0]  wr_data_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [FIELD_W*N_DEV-1:0]  rd_data_o,
    output logic                      ser_en_o,
    output logic                      ser_clk_o,
    output logic                      ser_dq_o,
    output logic                      ser_dq_oe_o,
    input  logic                      ser_dq_i
);
    localparam int unsigned W  = FIELD_W * N_DEV;
    localparam int unsigned CW = $clog2(W + 1);

    host_state_t   state_q, state_d;
    logic          tick;
    logic          rd_mode_q;
    logic [CW-1:0] edge_q;
    logic          last_bit;
    logic          start_ok;
    logic          shift_en;
    logic          en_q, sclk_q, oe_q, done_q;

    assign start_ok = start_i && (state_q == ST_IDLE);
    assign last_bit = (edge_q == CW'(W - 1));

    pot_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    // Read: one shift at the end of setup, then one after each rising edge
    // except the last. Write: a shift after each rising edge except the last.
    assign shift_en = tick && (((state_q == ST_SETUP) && rd_mode_q) ||
                               ((state_q == ST_HIGH) && !last_bit));

    pot_frame_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (wr_data_i),
        .shift    (shift_en),
        .ser_in   (ser_dq_i),
        .word     (rd_data_o),
        .msb      (ser_dq_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (tick)    state_d = ST_LEAD;
            ST_LEAD:  if (tick)    state_d = ST_HIGH;
            ST_HIGH:  if (tick)    state_d = last_bit ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)    state_d = ST_HIGH;
            ST_TRAIL: if (tick)    state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register with bit counter and mode flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            edge_q    <= '0;
            rd_mode_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                rd_mode_q <= rd_i;
                edge_q    <= '0;
            end else if (tick && (state_q == ST_HIGH)) begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sclk_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            en_q   <= (state_d == ST_LEAD) || (state_d == ST_HIGH) ||
                      (state_d == ST_LOW)  || (state_d == ST_TRAIL);
            sclk_q <= (state_d == ST_HIGH);
            if (start_ok) begin
                oe_q <= !rd_i;
            end else if (state_d == ST_IDLE) begin
                oe_q <= 1'b0;
            end
            done_q <= (state_q == ST_TRAIL) && tick;
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign ser_en_o    = en_q;
    assign ser_clk_o   = sclk_q;
    assign ser_dq_oe_o = oe_q;
endmodule

// File: rtl/pot_chain_host_chk.sv
module pot_chain_host_chk
    import pot_host_pkg::*;
#(
    parameter int unsigned N_DEV     = 2,
    parameter int unsigned PHASE_CYC = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     ser_en_o,
    input logic                     ser_clk_o,
    input logic                     ser_dq_o,
    input logic                     ser_dq_oe_o
);
    localparam int unsigned W = FIELD_W * N_DEV;

    logic        clk_prev_q;
    int unsigned rise_cnt_q, hi_cnt_q, lo_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            rise_cnt_q <= 0;
            hi_cnt_q   <= 0;
            lo_cnt_q   <= 0;
        end else begin
            clk_prev_q <= ser_clk_o;
            if (!ser_en_o) rise_cnt_q <= 0;
            else if (ser_clk_o && !clk_prev_q) rise_cnt_q <= rise_cnt_q + 1;
            hi_cnt_q <= ser_clk_o ? hi_cnt_q + 1 : 0;
            lo_cnt_q <= (ser_en_o && !ser_clk_o) ? lo_cnt_q + 1 : 0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ser_en_o && !ser_clk_o && !ser_dq_oe_o)); // R1
    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en_o) |-> (rise_cnt_q == W)); // R2
    AST_OE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ser_dq_oe_o)); // R4
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> (lo_cnt_q == PHASE_CYC)); // R5
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> (hi_cnt_q == PHASE_CYC)); // R6
    AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && ser_dq_oe_o) |-> $stable(ser_dq_o)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !ser_en_o && $past(busy_o))); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && ser_clk_o) |=> busy_o); // R9
endmodule

bind pot_chain_host pot_chain_host_chk #(
    .N_DEV     (N_DEV),
    .PHASE_CYC (PHASE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ser_en_o    (ser_en_o),
    .ser_clk_o   (ser_clk_o),
    .ser_dq_o    (ser_dq_o),
    .ser_dq_oe_o (ser_dq_oe_o)
);

// File: tb/test_pot_chain_host.sv
module test_pot_chain_host;
    localparam int N_DEV = 2;
    localparam int P     = 3;
    localparam int W     = 17 * N_DEV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         rd_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] rd_data_o;
    logic         ser_en_o, ser_clk_o, ser_dq_o, ser_dq_oe_o;
    logic         dq_line;

    int n_tests = 0;
    int n_fail  = 0;

    // Chain model: shift in on each serial rising edge, cascade out at the top
    logic [W-1:0] chain_q = '0;
    assign dq_line = ser_dq_oe_o ? ser_dq_o : chain_q[W-1];
    always @(posedge ser_clk_o) if (ser_en_o) chain_q <= {chain_q[W-2:0], dq_line};

    always #10 clk = ~clk;

    pot_chain_host #(.N_DEV(N_DEV), .PHASE_CYC(P)) i_pot_chain_host (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .wr_data_i(wr_data_i), .busy_o(busy_o), .done_o(done_o),
        .rd_data_o(rd_data_o), .ser_en_o(ser_en_o), .ser_clk_o(ser_clk_o),
        .ser_dq_o(ser_dq_o), .ser_dq_oe_o(ser_dq_oe_o), .ser_dq_i(dq_line)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] mk_field(input logic stk, input logic [7:0] w1, input logic [7:0] w0);
        return {stk, w1, w0};
    endfunction

    int           r_busy, r_rises, r_lead, r_tail;
    bit           r_done, r_width_bad, r_dq_bad, r_oe_bad;
    logic [W-1:0] r_rd;

    task automatic run_xfer(input logic rd, input logic [W-1:0] data, input bit inject);
        logic pclk, pdq;
        int   hi_run, lo_run;
        r_busy = 0; r_rises = 0; r_lead = 0; r_tail = 0;
        r_done = 0; r_width_bad = 0; r_dq_bad = 0; r_oe_bad = 0;
        pclk = 1'b0; pdq = 1'b0; hi_run = 0; lo_run = 0;
        @(negedge clk);
        start_i = 1'b1; rd_i = rd; wr_data_i = data;
        @(negedge clk);
        start_i = 1'b0; rd_i = ~rd; wr_data_i = ~data;
        for (int k = 0; k < 5000 && !r_done; k++) begin
            if (busy_o) r_busy++;
            if (done_o) begin
                r_done = 1;
                r_rd = rd_data_o;
            end
            if (ser_clk_o && !pclk) begin
                r_rises++;
                if (r_rises > 1 && lo_run != P) r_width_bad = 1;
            end
            if (ser_clk_o) hi_run++;
            else if (pclk) begin
                if (hi_run != P) r_width_bad = 1;
                hi_run = 0;
            end
            lo_run = (ser_en_o && !ser_clk_o) ? lo_run + 1 : 0;
            if (ser_en_o && !ser_clk_o && r_rises == 0) r_lead++;
            if (ser_en_o && !ser_clk_o && r_rises == W) r_tail++;
            if (ser_clk_o && ser_dq_oe_o && ser_dq_o !== pdq) r_dq_bad = 1;
            if (busy_o && ser_dq_oe_o !== !rd) r_oe_bad = 1;
            if (inject && k == 20) begin start_i = 1'b1; rd_i = ~rd; wr_data_i = ~data; end
            if (inject && k == 21) start_i = 1'b0;
            pclk = ser_clk_o;
            pdq  = ser_dq_o;
            if (!r_done) @(negedge clk);
        end
        start_i = 1'b0;
        chk(r_done, "R8 done seen", r_done, 1);
        chk(r_busy == P*(2*W+2), "R10 busy length", r_busy, P*(2*W+2));
        chk(r_rises == W, "R2 clock rises", r_rises, W);
        chk(r_lead == P && r_tail == P, "R5 enable lead/tail", {r_lead[31:0], r_tail[31:0]}, {P[31:0], P[31:0]});
        chk(!r_width_bad, "R6 phase widths", r_width_bad, 0);
        chk(!r_oe_bad, "R4 output enable per mode", r_oe_bad, 0);
        if (!rd) chk(!r_dq_bad, "R7 data stable across high", r_dq_bad, 0);
        @(negedge clk);
        chk(!done_o && !busy_o, "R8 done one cycle", {done_o, busy_o}, 0);
    endtask

    task automatic t_reset();
        chk({busy_o, done_o, ser_en_o, ser_clk_o, ser_dq_oe_o} == 5'b0, "R1 reset outputs",
            {busy_o, done_o, ser_en_o, ser_clk_o, ser_dq_oe_o}, 0);
    endtask

    task automatic t_write(input logic [W-1:0] v);
        run_xfer(1'b0, v, 1'b0);
        chk(chain_q == v, "R3 chain after write", chain_q, v);
    endtask

    task automatic t_read(input logic [W-1:0] s);
        chain_q = s;
        run_xfer(1'b1, ~s, 1'b0);
        chk(r_rd == s, "R4 read data", r_rd, s);
        chk(chain_q == s, "R4 chain unchanged by read", chain_q, s);
    endtask

    task automatic t_busy_ignore(input logic [W-1:0] v);
        run_xfer(1'b0, v, 1'b1);
        chk(chain_q == v, "R9 chain after ignored start", chain_q, v);
        repeat (5) @(negedge clk);
        chk(!busy_o && !ser_en_o, "R9 no second transfer", {busy_o, ser_en_o}, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        // farthest device first: stack=1, w1=A5, w0=3C; nearest: stack=0, w1=80, w0=01
        t_write({mk_field(1'b1, 8'hA5, 8'h3C), mk_field(1'b0, 8'h80, 8'h01)});
        t_write({W{1'b1}});
        t_read({mk_field(1'b0, 8'h12, 8'hFE), mk_field(1'b1, 8'h7F, 8'h00)});
        t_read({(W/2){2'b10}});
        t_busy_ignore({mk_field(1'b0, 8'h01, 8'h80), mk_field(1'b1, 8'hC3, 8'h5A)});
        t_write('0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule